// File: doc/BRIEF.md
# Per-Hart Timer and Inter-Processor Interrupt Unit

This block serves a cluster of harts with two kinds of machine-level interrupt. A single shared 64-bit time value counts timebase ticks. Each hart owns a 64-bit deadline register. Each hart's timer line is raised whenever the shared time has reached or passed that hart's deadline. Each hart also owns a one-bit doorbell. Any agent on the register bus can ring or silence a hart's doorbell, and the doorbell drives that hart's software interrupt line directly.

Software arms a timer by writing an absolute target time into the deadline, for example the current time plus the number of ticks in the wanted interval. It silences a pending timer only by writing a later deadline; there is no acknowledge. All registers sit in one address window and are reached through a 32-bit data path. Each 64-bit register is split into a low word at its base offset and a high word at base + 4. Address bits [1:0] are ignored.

Top module: `htip_top`

## Requirements
- R1: After reset the time value is 0, every deadline reads 0xFFFFFFFF in both words, every doorbell reads 0, and all interrupt outputs are low.
- R2: When `tb_tick` is high in a cycle with no time write, the time value grows by exactly one at the clock edge, carrying from the low word (offset 0xBFF8) into the high word (offset 0xBFFC). When `tb_tick` is low and there is no time write, it holds.
- R3: The time words are readable and writable at 0xBFF8 (bits 31:0) and 0xBFFC (bits 63:32). A write replaces only the addressed word, and the count does not advance in the cycle of that write even when `tb_tick` is high.
- R4: Hart h's doorbell is the word at offset 4×h. Only bit 0 is stored, and the upper 31 bits read as 0. `msw_irq[h]` equals the stored bit from the edge that writes it and holds until a later write changes it.
- R5: Hart h's deadline is at offset 0x4000 + 8×h, with bits 31:0 at +0 and bits 63:32 at +4. Each word reads back what was last written to it.
- R6: `mtm_irq[h]` is high exactly when time ≥ deadline of hart h (unsigned). It is re-evaluated every cycle, so it reflects the register values in the cycle after the edge that updates them.
- R7: A pending timer line drops when a deadline above the current time is written. No other action clears it.
- R8: Any offset outside the doorbell words, the deadline words and the two time words reads as 0. Writes to such offsets change no register and no interrupt output.
- R9: A write to one hart's doorbell or deadline leaves every other hart's registers and interrupt lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Timebase tick, one cycle wide per count step |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, captured at the clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| msw_irq | output | NUM_HARTS | Software interrupt per hart |
| mtm_irq | output | NUM_HARTS | Timer interrupt per hart |

## Verification
Directed cases cover these corners:
- deadlines a few ticks ahead of the time, ticked across the equality point, which separates ≥ from > and shows that a later deadline clears the line;
- a low-word count at 0xFFFFFFFE ticked twice, which shows the carry;
- a tick in the same cycle as a time write, which shows the write wins.

Doorbell writes of all-ones and zero show bit-0 masking and per-hart isolation. Writes just past the last doorbell and the last deadline show that unmapped space is dead.

A seeded random phase mixes ticks, doorbell writes, deadline words written in either order close to the current time, time writes and unmapped writes. After each step it checks every interrupt line and one read against a model kept in the bench. Comparing both lines every cycle catches compare, decode and ordering faults.

// File: rtl/htip_pkg.sv
package htip_pkg;
   localparam int HART_IDX_W = 12;
   localparam int MAX_HARTS  = 4095;
   localparam int SWI_BASE   = 'h0000;
   localparam int CMP_BASE   = 'h4000;
   localparam int TIME_BASE  = 'hBFF8;
   localparam int REG_W      = 64;
   localparam int BUS_W      = 32;

   typedef enum logic [1:0] {
      TGT_NONE,
      TGT_SWI,
      TGT_CMP,
      TGT_TIME
   } tgt_e;

   typedef struct packed {
      tgt_e                  tgt;
      logic [HART_IDX_W-1:0] hart;
      logic                  upper;
   } acc_t;

   function automatic logic [BUS_W-1:0] half_sel(input logic [REG_W-1:0] v,
                                                 input logic upper);
      return upper ? v[REG_W-1:BUS_W] : v[BUS_W-1:0];
   endfunction
endpackage

// File: rtl/htip_decode.sv
module htip_decode
   import htip_pkg::*;
#(
   parameter int NUM_HARTS = 4,
   parameter int ADDR_W    = 16
)(
   input  logic [ADDR_W-1:0] addr,
   output acc_t              acc
);
   localparam logic [ADDR_W-1:0] SWI_END = ADDR_W'(SWI_BASE + 4 * NUM_HARTS);
   localparam logic [ADDR_W-1:0] CMP_LO  = ADDR_W'(CMP_BASE);
   localparam logic [ADDR_W-1:0] CMP_END = ADDR_W'(CMP_BASE + 8 * NUM_HARTS);
   localparam logic [ADDR_W-1:0] TIME_LO = ADDR_W'(TIME_BASE);
   localparam logic [ADDR_W-1:0] WMASK   = ~ADDR_W'(3);

   logic [ADDR_W-1:0] word_a;
   logic [ADDR_W-1:0] cmp_off;

   always_comb begin
      word_a  = addr & WMASK;
      cmp_off = word_a - CMP_LO;
      acc     = '0;
      if (word_a < SWI_END) begin
         acc.tgt  = TGT_SWI;
         acc.hart = HART_IDX_W'(word_a >> 2);
      end else if (word_a >= CMP_LO && word_a < CMP_END) begin
         acc.tgt   = TGT_CMP;
         acc.hart  = HART_IDX_W'(cmp_off >> 3);
         acc.upper = word_a[2];
      end else if ((word_a >> 3) == (TIME_LO >> 3)) begin
         acc.tgt   = TGT_TIME;
         acc.upper = word_a[2];
      end
   end
endmodule

// File: rtl/htip_time.sv
module htip_time
   import htip_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             we_lo,
   input  logic             we_hi,
   input  logic [BUS_W-1:0] wdata,
   output logic [REG_W-1:0] time_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
      end else if (we_lo) begin
         time_q[BUS_W-1:0] <= wdata;
      end else if (we_hi) begin
         time_q[REG_W-1:BUS_W] <= wdata;
      end else if (tick) begin
         time_q <= time_q + REG_W'(1);
      end
   end
endmodule

// File: rtl/htip_slot.sv
module htip_slot
   import htip_pkg::*;
#(
   parameter bit REG_TIMER_IRQ = 1'b0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] time_q,
   input  logic             swi_we,
   input  logic             cmp_we_lo,
   input  logic             cmp_we_hi,
   input  logic [BUS_W-1:0] wdata,
   output logic             swi_q,
   output logic [REG_W-1:0] cmp_q,
   output logic             tmr_irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         swi_q <= 1'b0;
         cmp_q <= '1;
      end else begin
         if (swi_we)    swi_q                 <= wdata[0];
         if (cmp_we_lo) cmp_q[BUS_W-1:0]      <= wdata;
         if (cmp_we_hi) cmp_q[REG_W-1:BUS_W]  <= wdata;
      end
   end

   generate
      if (REG_TIMER_IRQ) begin : g_reg_irq
         logic irq_r;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_r <= 1'b0;
            else        irq_r <= (time_q >= cmp_q);
         end
         assign tmr_irq = irq_r;
      end else begin : g_comb_irq
         assign tmr_irq = (time_q >= cmp_q);
      end
   endgenerate
endmodule

// File: rtl/htip_top.sv
module htip_top
   import htip_pkg::*;
#(
   parameter int NUM_HARTS     = 4,
   parameter int ADDR_W        = 16,
   parameter bit REG_TIMER_IRQ = 1'b0
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tb_tick,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic                 bus_we,
   output logic [31:0]          bus_rdata,
   output logic [NUM_HARTS-1:0] msw_irq,
   output logic [NUM_HARTS-1:0] mtm_irq
);
   generate
      if (NUM_HARTS < 1 || NUM_HARTS > MAX_HARTS) begin : g_bad_harts
         $error("htip_top: NUM_HARTS out of range");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("htip_top: ADDR_W must cover the 0xBFFC offset");
      end
   endgenerate

   acc_t             acc;
   logic [REG_W-1:0] time_q;
   logic             t_we_lo;
   logic             t_we_hi;
   logic [BUS_W-1:0] rd_part [NUM_HARTS];
   logic [BUS_W-1:0] rd_mux;

   htip_decode #(
      .NUM_HARTS(NUM_HARTS),
      .ADDR_W   (ADDR_W)
   ) u_dec (
      .addr(bus_addr),
      .acc (acc)
   );

   assign t_we_lo = bus_we && (acc.tgt == TGT_TIME) && !acc.upper;
   assign t_we_hi = bus_we && (acc.tgt == TGT_TIME) &&  acc.upper;

   htip_time u_time (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tb_tick),
      .we_lo (t_we_lo),
      .we_hi (t_we_hi),
      .wdata (bus_wdata),
      .time_q(time_q)
   );

   generate
      for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
         logic             sel;
         logic             swi_q;
         logic [REG_W-1:0] cmp_q;
         logic             tmr;

         assign sel = (acc.hart == HART_IDX_W'(h));

         htip_slot #(
            .REG_TIMER_IRQ(REG_TIMER_IRQ)
         ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .time_q   (time_q),
            .swi_we   (bus_we && sel && (acc.tgt == TGT_SWI)),
            .cmp_we_lo(bus_we && sel && (acc.tgt == TGT_CMP) && !acc.upper),
            .cmp_we_hi(bus_we && sel && (acc.tgt == TGT_CMP) &&  acc.upper),
            .wdata    (bus_wdata),
            .swi_q    (swi_q),
            .cmp_q    (cmp_q),
            .tmr_irq  (tmr)
         );

         assign msw_irq[h] = swi_q;
         assign mtm_irq[h] = tmr;

         always_comb begin
            rd_part[h] = '0;
            if (sel && acc.tgt == TGT_SWI)
               rd_part[h] = {{(BUS_W-1){1'b0}}, swi_q};
            else if (sel && acc.tgt == TGT_CMP)
               rd_part[h] = half_sel(cmp_q, acc.upper);
         end
      end
   endgenerate

   always_comb begin
      rd_mux = (acc.tgt == TGT_TIME) ? half_sel(time_q, acc.upper) : '0;
      for (int h = 0; h < NUM_HARTS; h++) begin
         rd_mux = rd_mux | rd_part[h];
      end
   end

   assign bus_rdata = rd_mux;
endmodule

// File: rtl/htip_chk.sv
module htip_chk #(
   parameter int NUM_HARTS = 4,
   parameter int ADDR_W    = 16
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tb_tick,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 swi_wbit,
   input logic                 bus_we,
   input logic [31:0]          bus_rdata,
   input logic [NUM_HARTS-1:0] msw_irq,
   input logic [NUM_HARTS-1:0] mtm_irq,
   input logic [63:0]          time_q
);
   logic [ADDR_W-1:0] al;
   logic              mapped;

   assign al = bus_addr & ~ADDR_W'(3);
   assign mapped = (al < ADDR_W'(4 * NUM_HARTS))
                || (al >= ADDR_W'('h4000) && al < ADDR_W'('h4000 + 8 * NUM_HARTS))
                || ((al >> 3) == (ADDR_W'('hBFF8) >> 3));

   // R2
   time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && tb_tick) |=> (time_q == $past(time_q) + 64'd1));

   // R2
   time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && !tb_tick) |=> $stable(time_q));

   // R4
   swi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(msw_irq));

   // R8
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == 32'd0));

   generate
      for (genvar h = 0; h < NUM_HARTS; h++) begin : g_h
         // R4
         swi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && al == ADDR_W'(4 * h)) |=> (msw_irq[h] == $past(swi_wbit)));

         // R6
         tmr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mtm_irq[h] && !bus_we && time_q != 64'hFFFF_FFFF_FFFF_FFFF) |=> mtm_irq[h]);
      end
   endgenerate
endmodule

bind htip_top htip_chk #(
   .NUM_HARTS(NUM_HARTS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tb_tick  (tb_tick),
   .bus_addr (bus_addr),
   .swi_wbit (bus_wdata[0]),
   .bus_we   (bus_we),
   .bus_rdata(bus_rdata),
   .msw_irq  (msw_irq),
   .mtm_irq  (mtm_irq),
   .time_q   (time_q)
);

// File: tb/htip_top_test.sv
module htip_top_test;
   localparam int NH = 4;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tb_tick = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_rdata;
   logic [NH-1:0] msw_irq;
   logic [NH-1:0] mtm_irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [63:0] m_time;
   logic [63:0] m_cmp [NH];
   logic        m_swi [NH];

   htip_top #(.NUM_HARTS(NH), .ADDR_W(AW)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tb_tick  (tb_tick),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .bus_rdata(bus_rdata),
      .msw_irq  (msw_irq),
      .mtm_irq  (mtm_irq)
   );

   // 100 MHz: 10 time units per period
   always #5 clk = ~clk;

   task automatic report(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
      int ai;
      int h;
      ai = int'(a) & ~3;
      if (ai < 4 * NH) return {31'd0, m_swi[ai / 4]};
      if (ai >= 'h4000 && ai < 'h4000 + 8 * NH) begin
         h = (ai - 'h4000) / 8;
         return ((ai & 4) != 0) ? m_cmp[h][63:32] : m_cmp[h][31:0];
      end
      if (ai == 'hBFF8) return m_time[31:0];
      if (ai == 'hBFFC) return m_time[63:32];
      return 32'd0;
   endfunction

   task automatic model_apply(input logic we, input logic [AW-1:0] a,
                              input logic [31:0] d, input logic tk);
      int  ai;
      int  h;
      bit  twr;
      ai  = int'(a) & ~3;
      twr = 1'b0;
      if (we) begin
         if (ai < 4 * NH) m_swi[ai / 4] = d[0];
         else if (ai >= 'h4000 && ai < 'h4000 + 8 * NH) begin
            h = (ai - 'h4000) / 8;
            if ((ai & 4) != 0) m_cmp[h][63:32] = d;
            else               m_cmp[h][31:0]  = d;
         end else if (ai == 'hBFF8) begin
            m_time[31:0] = d; twr = 1'b1;
         end else if (ai == 'hBFFC) begin
            m_time[63:32] = d; twr = 1'b1;
         end
      end
      if (tk && !twr) m_time = m_time + 64'd1;
   endtask

   task automatic step(input logic we, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic tk);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d; tb_tick = tk;
      @(posedge clk);
      model_apply(we, a, d, tk);
      #1;
      bus_we = 1'b0; tb_tick = 1'b0;
   endtask

   task automatic chk_rd(input logic [AW-1:0] a, input string tag);
      logic [31:0] e;
      @(negedge clk);
      bus_we = 1'b0; tb_tick = 1'b0; bus_addr = a;
      #1;
      e = exp_read(a);
      report(bus_rdata === e, tag, bus_rdata, e);
   endtask

   task automatic chk_lit(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_we = 1'b0; tb_tick = 1'b0; bus_addr = a;
      #1;
      report(bus_rdata === e, tag, bus_rdata, e);
   endtask

   task automatic chk_irq(input string tag);
      @(negedge clk);
      bus_we = 1'b0; tb_tick = 1'b0;
      #1;
      for (int h = 0; h < NH; h++) begin
         report(msw_irq[h] === m_swi[h], {tag, " sw line"},
                {31'd0, msw_irq[h]}, {31'd0, m_swi[h]});
         report(mtm_irq[h] === (m_time >= m_cmp[h]), {tag, " timer line"},
                {31'd0, mtm_irq[h]}, {31'd0, (m_time >= m_cmp[h])});
      end
   endtask

   function automatic logic [AW-1:0] pick_addr(input int r);
      case (r % 6)
         0: return AW'(4 * (r % NH));
         1: return AW'('h4000 + 8 * (r % NH));
         2: return AW'('h4004 + 8 * (r % NH));
         3: return AW'('hBFF8);
         4: return AW'('hBFFC);
         default: return AW'('h8000 + 4 * (r % 64));
      endcase
   endfunction

   initial begin
      #1_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      int          h;
      int          r;
      void'($urandom(32'd2417));
      m_time = '0;
      for (int i = 0; i < NH; i++) begin
         m_cmp[i] = '1;
         m_swi[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_lit(16'hBFF8, 32'd0, "R1 time low");
      chk_lit(16'hBFFC, 32'd0, "R1 time high");
      chk_lit(16'h4008, 32'hFFFF_FFFF, "R1 deadline low");
      chk_lit(16'h400C, 32'hFFFF_FFFF, "R1 deadline high");
      chk_lit(16'h0004, 32'd0, "R1 doorbell");
      chk_irq("R1");

      // R4 bit-0 masking, R9 isolation
      step(1'b1, 16'h0008, 32'hFFFF_FFFF, 1'b0);
      chk_lit(16'h0008, 32'd1, "R4 doorbell read");
      chk_lit(16'h0004, 32'd0, "R9 neighbour doorbell");
      chk_irq("R4 set");
      step(1'b1, 16'h0008, 32'hFFFF_FFFE, 1'b0);
      chk_irq("R4 clear");

      // R2 carry, R3 write beats tick
      step(1'b1, 16'hBFF8, 32'hFFFF_FFFE, 1'b0);
      step(1'b0, 16'h0000, 32'd0, 1'b1);
      step(1'b0, 16'h0000, 32'd0, 1'b1);
      chk_lit(16'hBFF8, 32'd0, "R2 carry low");
      chk_lit(16'hBFFC, 32'd1, "R2 carry high");
      step(1'b1, 16'hBFF8, 32'd5, 1'b1);
      chk_lit(16'hBFF8, 32'd5, "R3 write wins low");
      chk_lit(16'hBFFC, 32'd1, "R3 other half kept");

      // R5 R6 R7 deadline crossing
      step(1'b1, 16'hBFFC, 32'd0, 1'b0);
      step(1'b1, 16'hBFF8, 32'd100, 1'b0);
      step(1'b1, 16'h400C, 32'd0, 1'b0);
      step(1'b1, 16'h4008, 32'd105, 1'b0);
      chk_lit(16'h4008, 32'd105, "R5 deadline low");
      chk_lit(16'h400C, 32'd0, "R5 deadline high");
      chk_rd(16'h4000, "R9 other deadline");
      repeat (4) step(1'b0, 16'h0000, 32'd0, 1'b1);
      chk_irq("R6 before");
      step(1'b0, 16'h0000, 32'd0, 1'b1);
      @(negedge clk); #1;
      report(mtm_irq === 4'b0010, "R6 at equality", {28'd0, mtm_irq}, 32'h2);
      repeat (3) step(1'b0, 16'h0000, 32'd0, 1'b1);
      chk_irq("R6 after");
      step(1'b1, 16'h4008, 32'd1000, 1'b0);
      @(negedge clk); #1;
      report(mtm_irq === 4'b0000, "R7 cleared", {28'd0, mtm_irq}, 32'h0);

      // R8 unmapped space
      step(1'b1, AW'(4 * NH), 32'd1, 1'b0);
      chk_lit(AW'(4 * NH), 32'd0, "R8 past doorbells");
      chk_irq("R8 doorbell write");
      step(1'b1, AW'('h4000 + 8 * NH), 32'd0, 1'b0);
      chk_lit(AW'('h4000 + 8 * NH), 32'd0, "R8 past deadlines");
      chk_irq("R8 deadline write");
      step(1'b1, 16'hBFF0, 32'd0, 1'b0);
      chk_lit(16'hBFF0, 32'd0, "R8 below time");
      chk_rd(16'hBFFB, "R3 low address bits ignored");

      // random phase
      for (int it = 0; it < 400; it++) begin
         r = int'($urandom % 10);
         h = int'($urandom % NH);
         case (r)
            0, 1, 2: step(1'b0, 16'h0000, 32'd0, 1'b1);
            3: step(1'b1, AW'(4 * h), $urandom, $urandom % 2 == 0);
            4, 5: begin
               v = m_time + 64'($urandom % 24);
               if ($urandom % 2 == 0) begin
                  step(1'b1, AW'('h4004 + 8 * h), v[63:32], 1'b0);
                  step(1'b1, AW'('h4000 + 8 * h), v[31:0], 1'b1);
               end else begin
                  step(1'b1, AW'('h4000 + 8 * h), v[31:0], 1'b1);
                  step(1'b1, AW'('h4004 + 8 * h), v[63:32], 1'b0);
               end
            end
            6: step(1'b1, ($urandom % 2 == 0) ? 16'hBFF8 : 16'hBFFC,
                    $urandom % 64, $urandom % 2 == 0);
            7: step(1'b1, AW'('h8000 + 4 * ($urandom % 64)), $urandom, 1'b1);
            default: step(1'b1, pick_addr(int'($urandom % 1000) + 5 * 6 - 1), $urandom, 1'b1);
         endcase
         chk_irq("R6 R9 random");
         chk_rd(pick_addr(int'($urandom % 1000)), "R5 R8 random read");
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule